// File: doc/BRIEF.md
# Serial Host Register Port

This block lets an external processor read and write a 256-byte register and message space over a clocked serial link. The host holds an active-low select low for a whole frame and shifts bytes in on a serial clock. Every frame begins with an address byte and a control byte. Any data bytes that follow go to, or come from, consecutive addresses starting at the one given. While the two header bytes are shifted in, the port returns fixed check patterns so the host can confirm it is byte-aligned.

The byte format is not fixed. After each reset the port reads a two-byte setup pair and from it picks one of three framings:
- eight bits per byte, most significant bit first;
- eight bits per byte, least significant bit first;
- nine bits per byte, least significant bit first, where the ninth bit is a filler.

If the setup pair is not one of the three known pairs, the port stays silent until the next reset.

All serial inputs are brought into the system clock domain and sampled there. The host samples MISO before each rising serial clock edge. The storage is a simple behavioural array. A reset does not clear it.

Top module: `sreg_port`

## Requirements
- R1: For 12 system clock cycles after rst_ni is released, serial clock edges are ignored. A bit clocked in during that window does not shift the alignment of later bytes.
- R2: The first two bytes received after reset are always shifted most significant bit first. They select the framing: 0xFF then 0x00 gives 8-bit MSB-first; 0xFF then 0xFF gives 8-bit LSB-first; 0x00 then 0xFF gives 9-bit LSB-first. Once chosen, the framing holds until reset.
- R3: Any other setup pair leaves the port dead until reset. In that state miso_oe_o stays low, a later valid pair is not accepted, and no write reaches the storage.
- R4: During the address byte of a frame, MISO returns 0xAA. During the control byte it returns 0x55. Both are sent in the active bit order.
- R5: Control bit 7 set to 1 means read and set to 0 means write. Data byte n of a frame writes to, or reads from, address plus n.
- R6: The address counter wraps from 0xFF to 0x00 within a burst.
- R7: If any of control bits 6..0 is nonzero, the frame's data bytes do not write, and a read returns 0xFF for every data byte.
- R8: While ss_ni is high, miso_oe_o is low and serial clock edges are ignored. A partly shifted byte is discarded when ss_ni rises, and the next frame starts again at the address byte.
- R9: In LSB-first mode, address, control and data bits are taken and returned least significant first. This addresses the same storage cells as MSB-first mode.
- R10: In 9-bit mode, the ninth received bit of each byte is ignored, and the port drives 1 on MISO for the ninth bit.
- R11: During and right after reset, miso_oe_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock from the host, idle low, data sampled on rising edge |
| ss_ni | input | 1 | Active-low select, held low across a frame |
| mosi_i | input | 1 | Serial data from the host |
| miso_o | output | 1 | Serial data to the host, valid while miso_oe_o is high |
| miso_oe_o | output | 1 | Output enable for MISO; low means the line is not driven |

## Verification
Random write-then-read bursts of random length and start address are run in each of the three framings. Data written in the MSB-first framing is later read back in the LSB-first and 9-bit framings. This separates a correct bit order from one that is only self-consistent. A burst that starts at 0xFD tests the address wrap. Control bytes with reserved bits set test that writes are blocked and that reads are forced to 0xFF.

A stray clock pulse during the hold-off, a byte clocked while deselected, and a frame cut off mid-byte each show up as misaligned check patterns if the port handles them wrongly. A bad setup pair followed by a valid one shows that the dead state does not recover before reset.

// File: rtl/sreg_port_pkg.sv
package sreg_port_pkg;
  typedef enum logic [2:0] {
    CFG_FIRST, CFG_SECOND, CFG_MSB, CFG_LSB, CFG_NINE, CFG_DEAD
  } cfg_e;

  typedef enum logic [1:0] {PH_ADDR, PH_CTRL, PH_DATA} phase_e;

  localparam logic [7:0] INIT_MSB_A  = 8'hFF;
  localparam logic [7:0] INIT_MSB_B  = 8'h00;
  localparam logic [7:0] INIT_LSB_A  = 8'hFF;
  localparam logic [7:0] INIT_LSB_B  = 8'hFF;
  localparam logic [7:0] INIT_NINE_A = 8'h00;
  localparam logic [7:0] INIT_NINE_B = 8'hFF;

  function automatic logic cfg_live(cfg_e c);
    return (c == CFG_MSB) || (c == CFG_LSB) || (c == CFG_NINE);
  endfunction
endpackage

// File: rtl/sreg_port_sync.sv
module sreg_port_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] pipe_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) pipe_q[i] <= '0;
    end else begin
      pipe_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) pipe_q[i] <= pipe_q[i-1];
    end
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/sreg_port_shifter.sv
module sreg_port_shifter #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          sel_i,
  input  logic          sclk_i,
  input  logic          mosi_i,
  input  logic          lsb_i,
  input  logic          nine_i,
  input  logic [DW-1:0] tx_byte_i,
  output logic [DW-1:0] byte_o,
  output logic          byte_vld_o,
  output logic          miso_o,
  output logic          extra_bit_o
);
  localparam int CW = $clog2(DW + 1);
  localparam int PW = $clog2(DW);

  logic          sclk_d;
  logic          rise;
  logic [CW-1:0] cnt_q;
  logic [DW-1:0] rx_q, rx_nx;
  logic [PW-1:0] pos;
  logic          in_data;
  logic          at_last;

  assign rise    = sclk_i & ~sclk_d;
  assign in_data = (cnt_q < CW'(DW));
  assign pos     = lsb_i ? cnt_q[PW-1:0] : PW'(DW - 1) - cnt_q[PW-1:0];
  assign at_last = nine_i ? (cnt_q == CW'(DW)) : (cnt_q == CW'(DW - 1));

  always_comb begin
    rx_nx = rx_q;
    if (in_data) rx_nx[pos] = mosi_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_d     <= 1'b0;
      cnt_q      <= '0;
      rx_q       <= '0;
      byte_o     <= '0;
      byte_vld_o <= 1'b0;
    end else begin
      sclk_d     <= sclk_i;
      byte_vld_o <= 1'b0;
      if (!sel_i) begin
        cnt_q <= '0;
      end else if (rise && en_i) begin
        rx_q <= rx_nx;
        if (at_last) begin
          cnt_q      <= '0;
          byte_o     <= rx_nx;
          byte_vld_o <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  // filler bit of the 9-bit framing is always 1
  assign extra_bit_o = ~in_data;
  assign miso_o      = in_data ? tx_byte_i[pos] : 1'b1;
endmodule

// File: rtl/sreg_port_ctrl.sv
module sreg_port_ctrl
  import sreg_port_pkg::*;
#(
  parameter int          AW          = 8,
  parameter int          DW          = 8,
  parameter int          HOLD_CYCLES = 12,
  parameter logic [7:0]  HDR_A       = 8'hAA,
  parameter logic [7:0]  HDR_B       = 8'h55
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sel_i,
  input  logic [DW-1:0] byte_i,
  input  logic          byte_vld_i,
  input  logic [DW-1:0] rd_data_i,
  output logic          en_o,
  output logic          lsb_o,
  output logic          nine_o,
  output logic [DW-1:0] tx_byte_o,
  output logic          oe_o,
  output logic          we_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wdata_o,
  output cfg_e          cfg_o,
  output phase_e        phase_o
);
  localparam int HW = $clog2(HOLD_CYCLES + 1);

  logic [HW-1:0] hold_q;
  cfg_e          cfg_q;
  phase_e        phase_q;
  logic [DW-1:0] first_q;
  logic [AW-1:0] addr_q;
  logic          rd_q, ok_q;
  logic          live;

  function automatic cfg_e decode(logic [7:0] a, logic [7:0] b);
    if (a == INIT_MSB_A && b == INIT_MSB_B)   return CFG_MSB;
    if (a == INIT_LSB_A && b == INIT_LSB_B)   return CFG_LSB;
    if (a == INIT_NINE_A && b == INIT_NINE_B) return CFG_NINE;
    return CFG_DEAD;
  endfunction

  assign live = cfg_live(cfg_q);
  assign en_o = (hold_q == HW'(HOLD_CYCLES));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q  <= '0;
      cfg_q   <= CFG_FIRST;
      phase_q <= PH_ADDR;
      first_q <= '0;
      addr_q  <= '0;
      rd_q    <= 1'b0;
      ok_q    <= 1'b0;
    end else begin
      if (!en_o) hold_q <= hold_q + 1'b1;
      if (byte_vld_i) begin
        case (cfg_q)
          CFG_FIRST: begin
            first_q <= byte_i;
            cfg_q   <= CFG_SECOND;
          end
          CFG_SECOND: cfg_q <= decode(first_q, byte_i);
          CFG_MSB, CFG_LSB, CFG_NINE: begin
            case (phase_q)
              PH_ADDR: begin
                addr_q  <= byte_i[AW-1:0];
                phase_q <= PH_CTRL;
              end
              PH_CTRL: begin
                rd_q    <= byte_i[DW-1];
                ok_q    <= (byte_i[DW-2:0] == '0);
                phase_q <= PH_DATA;
              end
              default: addr_q <= addr_q + 1'b1;
            endcase
          end
          default: ;
        endcase
      end
      if (!sel_i) phase_q <= PH_ADDR;
    end
  end

  always_comb begin
    case (phase_q)
      PH_ADDR: tx_byte_o = HDR_A;
      PH_CTRL: tx_byte_o = HDR_B;
      default: tx_byte_o = (ok_q && rd_q) ? rd_data_i : '1;
    endcase
  end

  assign we_o    = byte_vld_i && live && (phase_q == PH_DATA) && ok_q && !rd_q;
  assign addr_o  = addr_q;
  assign wdata_o = byte_i;
  assign oe_o    = live && sel_i;
  assign lsb_o   = (cfg_q == CFG_LSB) || (cfg_q == CFG_NINE);
  assign nine_o  = (cfg_q == CFG_NINE);
  assign cfg_o   = cfg_q;
  assign phase_o = phase_q;
endmodule

// File: rtl/sreg_port_ram.sv
module sreg_port_ram #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[addr_i];
endmodule

// File: rtl/sreg_port.sv
module sreg_port
  import sreg_port_pkg::*;
#(
  parameter int AW          = 8,
  parameter int SYNC_STAGES = 2,
  parameter int HOLD_CYCLES = 12
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  input  logic ss_ni,
  input  logic mosi_i,
  output logic miso_o,
  output logic miso_oe_o
);
  localparam int DW = 8;

  logic          sclk_s, mosi_s, sel_s;
  logic          en, lsb, nine, oe, we, byte_vld, bit_out, extra_bit;
  logic [DW-1:0] rx_byte, tx_byte, rd_data, wdata;
  logic [AW-1:0] addr;
  cfg_e          cfg;
  phase_e        phase;

  sreg_port_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sclk_i, mosi_i, ~ss_ni}),
    .q_o   ({sclk_s, mosi_s, sel_s})
  );

  sreg_port_shifter #(.DW(DW)) u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en),
    .sel_i      (sel_s),
    .sclk_i     (sclk_s),
    .mosi_i     (mosi_s),
    .lsb_i      (lsb),
    .nine_i     (nine),
    .tx_byte_i  (tx_byte),
    .byte_o     (rx_byte),
    .byte_vld_o (byte_vld),
    .miso_o     (bit_out),
    .extra_bit_o(extra_bit)
  );

  sreg_port_ctrl #(.AW(AW), .DW(DW), .HOLD_CYCLES(HOLD_CYCLES)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sel_i     (sel_s),
    .byte_i    (rx_byte),
    .byte_vld_i(byte_vld),
    .rd_data_i (rd_data),
    .en_o      (en),
    .lsb_o     (lsb),
    .nine_o    (nine),
    .tx_byte_o (tx_byte),
    .oe_o      (oe),
    .we_o      (we),
    .addr_o    (addr),
    .wdata_o   (wdata),
    .cfg_o     (cfg),
    .phase_o   (phase)
  );

  sreg_port_ram #(.AW(AW), .DW(DW)) u_ram (
    .clk_i  (clk_i),
    .we_i   (we),
    .addr_i (addr),
    .wdata_i(wdata),
    .rdata_o(rd_data)
  );

  assign miso_oe_o = oe;
  assign miso_o    = oe & bit_out;
endmodule

// File: rtl/sreg_port_chk.sv
module sreg_port_chk
  import sreg_port_pkg::*;
#(
  parameter int AW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          sel,
  input logic          en,
  input logic          byte_vld,
  input logic          we,
  input logic          extra_bit,
  input logic [AW-1:0] addr,
  input cfg_e          cfg,
  input phase_e        phase,
  input logic          miso_o,
  input logic          miso_oe_o
);
  AST_NO_BYTE_IN_HOLDOFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en |-> !byte_vld); // R1

  AST_LIVE_STICKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_live(cfg) |=> cfg_live(cfg)); // R2

  AST_DEAD_STICKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg == CFG_DEAD) |=> (cfg == CFG_DEAD) && !miso_oe_o && !we); // R3

  AST_WRITE_IN_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we |-> (phase == PH_DATA) && byte_vld); // R5

  AST_ADDR_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_vld && cfg_live(cfg) && phase == PH_DATA && addr == '1) |=> (addr == '0)); // R6

  AST_OE_NEEDS_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miso_oe_o |-> sel); // R8

  AST_FILLER_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (miso_oe_o && extra_bit) |-> miso_o); // R10

  always_comb begin
    if (!rst_ni) AST_OE_IN_RESET: assert (!miso_oe_o); // R11
  end
endmodule

bind sreg_port sreg_port_chk #(.AW(AW)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .sel      (sel_s),
  .en       (en),
  .byte_vld (byte_vld),
  .we       (we),
  .extra_bit(extra_bit),
  .addr     (addr),
  .cfg      (cfg),
  .phase    (phase),
  .miso_o   (miso_o),
  .miso_oe_o(miso_oe_o)
);

// File: tb/sreg_port_test.sv
`timescale 1ns/1ps
module sreg_port_test;
  logic clk = 1'b0, rst_n = 1'b0, sclk = 1'b0, ss_n = 1'b1, mosi = 1'b0;
  logic miso, miso_oe;
  int   n_chk = 0, n_err = 0;
  bit   done = 1'b0;
  logic [7:0] model [256];

  localparam int F_MSB = 0, F_LSB = 1, F_NINE = 2;

  always #2 clk = ~clk;

  sreg_port uut (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .ss_ni(ss_n),
    .mosi_i(mosi), .miso_o(miso), .miso_oe_o(miso_oe)
  );

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one byte; samples MISO before each rising edge
  task automatic xfer(input logic [7:0] tx, input int fmt, input logic nth_in,
                      output logic [7:0] rx, output logic nth, output logic oe_all);
    int nb;
    nb = (fmt == F_NINE) ? 9 : 8;
    rx = '0; nth = 1'b0; oe_all = 1'b1;
    for (int i = 0; i < nb; i++) begin
      int pos;
      pos  = (fmt == F_MSB) ? 7 - i : i;
      mosi = (i == 8) ? nth_in : tx[pos];
      wait_clk(3);
      oe_all = oe_all & miso_oe;
      if (i < 8) rx[pos] = miso; else nth = miso;
      sclk = 1'b1; wait_clk(6);
      sclk = 1'b0; wait_clk(3);
    end
  endtask

  task automatic frame_on();  ss_n = 1'b0; wait_clk(6); endtask
  task automatic frame_off(); ss_n = 1'b1; wait_clk(6); endtask

  task automatic do_reset();
    ss_n = 1'b1; sclk = 1'b0; rst_n = 1'b0;
    wait_clk(3);
    chk("R11 oe in reset", miso_oe, 1'b0);
    rst_n = 1'b1;
    wait_clk(20);
    chk("R11 oe after reset", miso_oe, 1'b0);
  endtask

  task automatic send_init(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] r; logic n9, oe;
    frame_on();
    xfer(a, F_MSB, 1'b1, r, n9, oe);
    xfer(b, F_MSB, 1'b1, r, n9, oe);
    frame_off();
  endtask

  task automatic header(input logic [7:0] addr, input logic [7:0] ctl, input int fmt, input string tag);
    logic [7:0] r; logic n9, oe;
    xfer(addr, fmt, 1'b1, r, n9, oe);
    chk({tag, " R4 addr pattern"}, r, 8'hAA);
    xfer(ctl, fmt, 1'b1, r, n9, oe);
    chk({tag, " R4 ctrl pattern"}, r, 8'h55);
    if (fmt == F_NINE) chk({tag, " R10 filler"}, n9, 1'b1);
  endtask

  task automatic wr_burst(input logic [7:0] addr, input int len, input int fmt, input string tag);
    logic [7:0] r, a; logic n9, oe;
    frame_on();
    header(addr, 8'h00, fmt, tag);
    a = addr;
    for (int i = 0; i < len; i++) begin
      logic [7:0] d;
      d = 8'($urandom);
      xfer(d, fmt, 1'($urandom), r, n9, oe);
      model[a] = d;
      a = a + 8'd1;
    end
    frame_off();
  endtask

  task automatic rd_burst(input logic [7:0] addr, input logic [7:0] ctl, input int len,
                          input int fmt, input string tag);
    logic [7:0] r, a; logic n9, oe;
    frame_on();
    header(addr, ctl, fmt, tag);
    a = addr;
    for (int i = 0; i < len; i++) begin
      xfer(8'hFF, fmt, 1'b1, r, n9, oe);
      chk({tag, " R5 read data"}, r, (ctl == 8'h80) ? model[a] : 8'hFF);
      if (fmt == F_NINE) chk({tag, " R10 filler"}, n9, 1'b1);
      a = a + 8'd1;
    end
    frame_off();
  endtask

  task automatic random_bursts(input int fmt, input int count, input string tag);
    for (int k = 0; k < count; k++) begin
      logic [7:0] a; int len;
      a   = 8'($urandom);
      len = 1 + int'($urandom % 5);
      wr_burst(a, len, fmt, tag);
      rd_burst(a, 8'h80, len, fmt, tag);
    end
  endtask

  initial begin
    logic [7:0] r; logic n9, oe;
    void'($urandom(32'h5eed_0001));

    // R1: stray edge inside the hold-off window, select already low
    ss_n = 1'b0; rst_n = 1'b0; wait_clk(3);
    chk("R11 oe in reset", miso_oe, 1'b0);
    rst_n = 1'b1; wait_clk(1);
    mosi = 1'b1; sclk = 1'b1; wait_clk(3); sclk = 1'b0; wait_clk(20);
    xfer(8'hFF, F_MSB, 1'b1, r, n9, oe);
    xfer(8'h00, F_MSB, 1'b1, r, n9, oe);
    frame_off();
    rd_burst(8'h10, 8'h01, 0, F_MSB, "R1 holdoff");
    chk("R2 msb mode live", miso_oe, 1'b0);

    // R2/R5: MSB-first bursts
    random_bursts(F_MSB, 6, "R2 msb");
    // R6: wrap
    wr_burst(8'hFD, 5, F_MSB, "R6 wrap");
    rd_burst(8'hFD, 8'h80, 5, F_MSB, "R6 wrap");
    // fixed cells for cross-mode reads
    model[8'h01] = 8'h0F;
    model[8'h80] = 8'hC3;
    frame_on(); header(8'h01, 8'h00, F_MSB, "R9 setup");
    xfer(8'h0F, F_MSB, 1'b1, r, n9, oe); frame_off();
    frame_on(); header(8'h80, 8'h00, F_MSB, "R9 setup");
    xfer(8'hC3, F_MSB, 1'b1, r, n9, oe); frame_off();

    // R7: reserved control bits
    frame_on(); header(8'h01, 8'h01, F_MSB, "R7 blocked write");
    xfer(8'h77, F_MSB, 1'b1, r, n9, oe); frame_off();
    rd_burst(8'h01, 8'h80, 1, F_MSB, "R7 cell unchanged");
    rd_burst(8'h01, 8'h83, 2, F_MSB, "R7 forced ff");

    // R8: deselected clocking and cut-off byte
    chk("R8 oe deselected", miso_oe, 1'b0);
    xfer(8'h5A, F_MSB, 1'b1, r, n9, oe);
    chk("R8 oe during deselected clocking", oe, 1'b0);
    frame_on();
    for (int i = 0; i < 3; i++) begin
      mosi = 1'b1; wait_clk(3); sclk = 1'b1; wait_clk(6); sclk = 1'b0; wait_clk(3);
    end
    frame_off();
    rd_burst(8'h80, 8'h80, 1, F_MSB, "R8 realigned");

    // R9: LSB-first, reading cells written MSB-first
    do_reset();
    send_init(8'hFF, 8'hFF);
    rd_burst(8'h01, 8'h80, 1, F_LSB, "R9 lsb cross");
    rd_burst(8'h80, 8'h80, 1, F_LSB, "R9 lsb cross");
    random_bursts(F_LSB, 4, "R9 lsb");

    // R10: nine-bit framing
    do_reset();
    send_init(8'h00, 8'hFF);
    rd_burst(8'h80, 8'h80, 1, F_NINE, "R10 nine cross");
    random_bursts(F_NINE, 4, "R10 nine");

    // R3: unknown pair, then valid pair still refused
    do_reset();
    send_init(8'h12, 8'h34);
    frame_on();
    xfer(8'h80, F_MSB, 1'b1, r, n9, oe);
    chk("R3 dead oe", oe, 1'b0);
    xfer(8'h00, F_MSB, 1'b1, r, n9, oe);
    xfer(8'hEE, F_MSB, 1'b1, r, n9, oe);
    frame_off();
    send_init(8'hFF, 8'h00);
    frame_on();
    xfer(8'h80, F_MSB, 1'b1, r, n9, oe);
    chk("R3 dead after valid pair", oe, 1'b0);
    xfer(8'h00, F_MSB, 1'b1, r, n9, oe);
    xfer(8'hEE, F_MSB, 1'b1, r, n9, oe);
    frame_off();
    do_reset();
    send_init(8'hFF, 8'h00);
    rd_burst(8'h80, 8'h80, 1, F_MSB, "R3 no write while dead");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule